// File: doc/BRIEF.md
# Dual-Width Integer Coprocessor ALU

This block is the integer datapath of a coprocessor. It owns a small register file in which every entry is 64 bits wide, held as a lower and an upper 32-bit half. When the two halves are read as one 64-bit integer, the upper half is the most significant word. One operation can be issued each clock. An operation names a group, a code within that group, a destination register and two source registers. It can also carry a 32-bit word from the host.

Arithmetic, multiply and shift operations run at one of two widths. The 32-bit forms use only the lower halves and write only the lower half of the destination. The 64-bit forms use and write the full register. The transfer group moves host words into either half of a register and brings either half back out on a registered host read port. The same group holds the compares, which report sign, zero, carry and overflow in the top four bits of a flag word. Any code that is not assigned raises a one-cycle illegal strobe and leaves all state alone.

Every result is written at the clock edge that ends its issue cycle. The next operation, issued in the following cycle, therefore already sees the new value.

Top module: `dwcp_alu`

## Requirements
- R1: After reset, host_rdata, flag_word and illegal_op are zero, and both halves of every register read back as zero.
- R2: In group 0, code 0 writes host_wdata into the lower half of register rd and code 1 writes it into the upper half; the other half keeps its value. Code 2 returns the lower half of rs1 on host_rdata and code 3 returns the upper half. The value appears one cycle after issue and is held until the next read.
- R3: In group 1, code 5 sets rd to rs1 + rs2 and code 7 sets rd to rs1 - rs2, both modulo 2^64 over the full register. Carry and borrow pass from the lower half into the upper half.
- R4: In group 1, code 4 adds and code 6 subtracts the lower halves of rs1 and rs2, modulo 2^32. Every 32-bit operation (group 1 even codes, group 2 codes 0, 2 and 3, group 3 code 0) writes only the lower half of rd, and the upper half of rd keeps its value.
- R5: In group 1, code 0 is the 32-bit absolute value, code 1 the 64-bit absolute value, code 2 the 32-bit negate and code 3 the 64-bit negate, all in two's complement. The absolute value of the most negative number returns that same number.
- R6: In group 2, code 0 writes the low 32 bits of the product of the lower halves, and code 1 writes the low 64 bits of the product of the full registers. Code 2 adds the low 32-bit product to the lower half of rd. Code 3 subtracts it from the lower half of rd.
- R7: In group 3, code 0 shifts the lower half of rs1 into rd and code 1 shifts the full rs1 into rd. The amount is host_wdata read as a signed number. A non-negative amount shifts left, and a negative amount shifts right arithmetically by its magnitude. A magnitude at or above the operand width gives all zeros for a left shift and all copies of the sign bit for a right shift.
- R8: In group 0, code 4 compares the lower halves and code 5 compares the full registers, based on rs1 - rs2. The result is loaded into flag_word one cycle after issue: bit 31 = sign of the difference, bit 30 = operands equal, bit 29 = no borrow (rs1 >= rs2 unsigned), bit 28 = signed overflow, bits 27:0 = 0. flag_word keeps its value until the next compare.
- R9: The unassigned codes are group 0 codes 6 and 7, group 2 codes 4 to 7, and group 3 codes 2 to 7. Each one pulses illegal_op high for exactly the cycle after issue. It changes no register, no host_rdata and no flag_word.
- R10: When op_valid is low, no register, host_rdata or flag_word changes, and illegal_op stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is issued this cycle |
| op_group | input | 2 | Operation group: 0 transfer/compare, 1 arithmetic, 2 multiply, 3 shift |
| op_code | input | 3 | Operation code within the group |
| rd_idx | input | IDX_W | Destination register index |
| rs1_idx | input | IDX_W | First source register index |
| rs2_idx | input | IDX_W | Second source register index |
| host_wdata | input | 32 | Host word for moves, or the signed shift amount |
| host_rdata | output | 32 | Registered half-register read result |
| flag_word | output | 32 | Registered compare flags in bits 31:28 |
| illegal_op | output | 1 | One-cycle strobe for an unassigned code |

## Verification
The bench goes after the places where the two widths meet. A 32-bit add whose carry leaked upward would corrupt the destination's upper half. A 64-bit add or subtract that lost the cross-half carry would leave the upper word wrong by one. It drives shift amounts of zero, of plus and minus the operand width and beyond, and of the most negative 32-bit value. A shifter that used only the low amount bits would wrap around instead of filling with zeros or sign bits. A shifter that shifted right logically would lose the sign. Compares include equal operands, unsigned-versus-signed disagreements and signed overflow, so a swapped or inverted carry, or an overflow flag taken from the raw sign, shows up in flag_word. The absolute value of the most negative number and unassigned codes followed by read-back expose any stray write.

// File: rtl/cpalu_pkg.sv
package cpalu_pkg;

    localparam int HALF_W = 32;
    localparam int FULL_W = 2 * HALF_W;

    typedef enum logic [1:0] {
        GRP_XFER  = 2'd0,
        GRP_ARITH = 2'd1,
        GRP_MUL   = 2'd2,
        GRP_SHIFT = 2'd3
    } grp_e;

    // transfer / compare group codes
    localparam logic [2:0] XF_WR_LO  = 3'd0;
    localparam logic [2:0] XF_WR_HI  = 3'd1;
    localparam logic [2:0] XF_RD_LO  = 3'd2;
    localparam logic [2:0] XF_RD_HI  = 3'd3;
    localparam logic [2:0] XF_CMP32  = 3'd4;
    localparam logic [2:0] XF_CMP64  = 3'd5;

    // arithmetic group codes
    localparam logic [2:0] AR_ABS32  = 3'd0;
    localparam logic [2:0] AR_ABS64  = 3'd1;
    localparam logic [2:0] AR_NEG32  = 3'd2;
    localparam logic [2:0] AR_NEG64  = 3'd3;
    localparam logic [2:0] AR_ADD32  = 3'd4;
    localparam logic [2:0] AR_ADD64  = 3'd5;
    localparam logic [2:0] AR_SUB32  = 3'd6;
    localparam logic [2:0] AR_SUB64  = 3'd7;

    // multiply group codes
    localparam logic [2:0] ML_MUL32  = 3'd0;
    localparam logic [2:0] ML_MUL64  = 3'd1;
    localparam logic [2:0] ML_MAC32  = 3'd2;
    localparam logic [2:0] ML_MSC32  = 3'd3;

    // shift group codes
    localparam logic [2:0] SH_SH32   = 3'd0;
    localparam logic [2:0] SH_SH64   = 3'd1;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    typedef struct packed {
        logic               wr_lo;
        logic               wr_hi;
        logic [FULL_W-1:0]  wdata;
        logic               rd_upd;
        logic [HALF_W-1:0]  rd_val;
        logic               fl_upd;
        flags_t             fl;
        logic               illegal;
    } exec_out_t;

    function automatic flags_t cmp_flags32(input logic [HALF_W-1:0] x,
                                           input logic [HALF_W-1:0] y);
        logic [HALF_W:0] diff;
        flags_t f;
        diff = {1'b0, x} - {1'b0, y};
        f.n = diff[HALF_W-1];
        f.z = (diff[HALF_W-1:0] == '0);
        f.c = ~diff[HALF_W];
        f.v = (x[HALF_W-1] ^ y[HALF_W-1]) & (diff[HALF_W-1] ^ x[HALF_W-1]);
        return f;
    endfunction

    function automatic flags_t cmp_flags64(input logic [FULL_W-1:0] x,
                                           input logic [FULL_W-1:0] y);
        logic [FULL_W:0] diff;
        flags_t f;
        diff = {1'b0, x} - {1'b0, y};
        f.n = diff[FULL_W-1];
        f.z = (diff[FULL_W-1:0] == '0);
        f.c = ~diff[FULL_W];
        f.v = (x[FULL_W-1] ^ y[FULL_W-1]) & (diff[FULL_W-1] ^ x[FULL_W-1]);
        return f;
    endfunction

    function automatic logic [HALF_W-1:0] pack_flags(input flags_t f);
        return {f, {(HALF_W-4){1'b0}}};
    endfunction

endpackage

// File: rtl/cpalu_regfile.sv
module cpalu_regfile
    import cpalu_pkg::*;
#(
    parameter int NREGS = 16,
    localparam int IDX_W = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  ra_idx,
    input  logic [IDX_W-1:0]  rb_idx,
    input  logic [IDX_W-1:0]  rc_idx,
    output logic [FULL_W-1:0] ra_data,
    output logic [FULL_W-1:0] rb_data,
    output logic [FULL_W-1:0] rc_data,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              we_lo,
    input  logic              we_hi,
    input  logic [FULL_W-1:0] wdata
);

    logic [NREGS-1:0][HALF_W-1:0] lo_q;
    logic [NREGS-1:0][HALF_W-1:0] hi_q;

    for (genvar r = 0; r < NREGS; r++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                lo_q[r] <= '0;
                hi_q[r] <= '0;
            end else begin
                if (we_lo && (wr_idx == IDX_W'(r))) lo_q[r] <= wdata[HALF_W-1:0];
                if (we_hi && (wr_idx == IDX_W'(r))) hi_q[r] <= wdata[FULL_W-1:HALF_W];
            end
        end
    end

    assign ra_data = {hi_q[ra_idx], lo_q[ra_idx]};
    assign rb_data = {hi_q[rb_idx], lo_q[rb_idx]};
    assign rc_data = {hi_q[rc_idx], lo_q[rc_idx]};

    // A half without a write enable must not move (illegal codes, idle cycles).
    assert_hold_lo_R9: assert property (@(posedge clk) disable iff (rst)
        !we_lo |=> $stable(lo_q))
        else $error("lower halves changed without a write");
    assert_hold_hi_R10: assert property (@(posedge clk) disable iff (rst)
        !we_hi |=> $stable(hi_q))
        else $error("upper halves changed without a write");

endmodule

// File: rtl/cpalu_shifter.sv
module cpalu_shifter #(
    parameter int W = 32,
    localparam int SW = $clog2(W)
) (
    input  logic [W-1:0] din,
    input  logic [31:0]  amt,
    output logic [W-1:0] dout
);

    logic        go_right;
    logic [32:0] mag;

    always_comb begin
        go_right = amt[31];
        mag      = go_right ? (33'd0 - {amt[31], amt}) : {1'b0, amt};
        if (mag >= 33'(W)) begin
            dout = go_right ? {W{din[W-1]}} : '0;
        end else if (go_right) begin
            dout = W'($signed(din) >>> mag[SW-1:0]);
        end else begin
            dout = din << mag[SW-1:0];
        end
    end

endmodule

// File: rtl/cpalu_exec.sv
module cpalu_exec
    import cpalu_pkg::*;
(
    input  logic              valid,
    input  grp_e              grp,
    input  logic [2:0]        code,
    input  logic [FULL_W-1:0] src_a,
    input  logic [FULL_W-1:0] src_b,
    input  logic [FULL_W-1:0] dst_old,
    input  logic [HALF_W-1:0] host_word,
    output exec_out_t         res
);

    logic [HALF_W-1:0] a_lo, b_lo, d_lo, prod32;
    logic [FULL_W-1:0] prod64, sh64;
    logic [HALF_W-1:0] sh32;

    assign a_lo   = src_a[HALF_W-1:0];
    assign b_lo   = src_b[HALF_W-1:0];
    assign d_lo   = dst_old[HALF_W-1:0];
    assign prod32 = a_lo * b_lo;
    assign prod64 = src_a * src_b;

    cpalu_shifter #(.W(HALF_W)) u_sh32 (.din(a_lo),  .amt(host_word), .dout(sh32));
    cpalu_shifter #(.W(FULL_W)) u_sh64 (.din(src_a), .amt(host_word), .dout(sh64));

    logic [HALF_W-1:0] lo_n;
    logic [FULL_W-1:0] full_n;
    logic              is_lo, is_full;

    always_comb begin
        res     = '0;
        lo_n    = '0;
        full_n  = '0;
        is_lo   = 1'b0;
        is_full = 1'b0;
        unique case (grp)
            GRP_XFER: begin
                case (code)
                    XF_WR_LO: begin res.wr_lo = 1'b1; lo_n = host_word; end
                    XF_WR_HI: begin
                        res.wr_hi = 1'b1;
                        full_n    = {host_word, d_lo};
                    end
                    XF_RD_LO: begin res.rd_upd = 1'b1; res.rd_val = a_lo; end
                    XF_RD_HI: begin res.rd_upd = 1'b1; res.rd_val = src_a[FULL_W-1:HALF_W]; end
                    XF_CMP32: begin res.fl_upd = 1'b1; res.fl = cmp_flags32(a_lo, b_lo); end
                    XF_CMP64: begin res.fl_upd = 1'b1; res.fl = cmp_flags64(src_a, src_b); end
                    default:  res.illegal = 1'b1;
                endcase
            end
            GRP_ARITH: begin
                case (code)
                    AR_ABS32: begin is_lo = 1'b1; lo_n = a_lo[HALF_W-1] ? (~a_lo + 1'b1) : a_lo; end
                    AR_ABS64: begin is_full = 1'b1; full_n = src_a[FULL_W-1] ? (~src_a + 1'b1) : src_a; end
                    AR_NEG32: begin is_lo = 1'b1; lo_n = ~a_lo + 1'b1; end
                    AR_NEG64: begin is_full = 1'b1; full_n = ~src_a + 1'b1; end
                    AR_ADD32: begin is_lo = 1'b1; lo_n = a_lo + b_lo; end
                    AR_ADD64: begin is_full = 1'b1; full_n = src_a + src_b; end
                    AR_SUB32: begin is_lo = 1'b1; lo_n = a_lo - b_lo; end
                    default:  begin is_full = 1'b1; full_n = src_a - src_b; end
                endcase
            end
            GRP_MUL: begin
                case (code)
                    ML_MUL32: begin is_lo = 1'b1; lo_n = prod32; end
                    ML_MUL64: begin is_full = 1'b1; full_n = prod64; end
                    ML_MAC32: begin is_lo = 1'b1; lo_n = d_lo + prod32; end
                    ML_MSC32: begin is_lo = 1'b1; lo_n = d_lo - prod32; end
                    default:  res.illegal = 1'b1;
                endcase
            end
            default: begin
                case (code)
                    SH_SH32: begin is_lo = 1'b1; lo_n = sh32; end
                    SH_SH64: begin is_full = 1'b1; full_n = sh64; end
                    default: res.illegal = 1'b1;
                endcase
            end
        endcase

        if (is_lo)   res.wr_lo = 1'b1;
        if (is_full) begin res.wr_lo = 1'b1; res.wr_hi = 1'b1; end
        if (res.wr_hi) res.wdata = full_n;
        else           res.wdata = {dst_old[FULL_W-1:HALF_W], lo_n};

        if (!valid) res = '0;
    end

endmodule

// File: rtl/dwcp_alu.sv
module dwcp_alu
    import cpalu_pkg::*;
#(
    parameter int NREGS = 16,
    localparam int IDX_W = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             op_valid,
    input  logic [1:0]       op_group,
    input  logic [2:0]       op_code,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [IDX_W-1:0] rs1_idx,
    input  logic [IDX_W-1:0] rs2_idx,
    input  logic [31:0]      host_wdata,
    output logic [31:0]      host_rdata,
    output logic [31:0]      flag_word,
    output logic             illegal_op
);

    logic [FULL_W-1:0] rs1_data, rs2_data, rd_data;
    exec_out_t         ex;

    cpalu_regfile #(.NREGS(NREGS)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .ra_idx  (rs1_idx),
        .rb_idx  (rs2_idx),
        .rc_idx  (rd_idx),
        .ra_data (rs1_data),
        .rb_data (rs2_data),
        .rc_data (rd_data),
        .wr_idx  (rd_idx),
        .we_lo   (ex.wr_lo),
        .we_hi   (ex.wr_hi),
        .wdata   (ex.wdata)
    );

    cpalu_exec u_exec (
        .valid     (op_valid),
        .grp       (grp_e'(op_group)),
        .code      (op_code),
        .src_a     (rs1_data),
        .src_b     (rs2_data),
        .dst_old   (rd_data),
        .host_word (host_wdata),
        .res       (ex)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            host_rdata <= '0;
            flag_word  <= '0;
            illegal_op <= 1'b0;
        end else begin
            if (ex.rd_upd) host_rdata <= ex.rd_val;
            if (ex.fl_upd) flag_word  <= pack_flags(ex.fl);
            illegal_op <= ex.illegal;
        end
    end

    assert_move_lo_R2: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_group == 2'd0 && op_code == 3'd0) |-> (ex.wr_lo && !ex.wr_hi))
        else $error("lower-half move touched the upper half");

    assert_half_only_R4: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_group == 2'd1 && !op_code[0]) |-> !ex.wr_hi)
        else $error("32-bit arithmetic wrote the upper half");

    assert_shift_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_group == 2'd3 && op_code == 3'd0 && host_wdata == 32'd0)
            |-> (ex.wdata[HALF_W-1:0] == rs1_data[HALF_W-1:0]))
        else $error("zero shift altered the operand");

    assert_flag_eq_R8: assert property (@(posedge clk) disable iff (rst)
        flag_word[30] |-> (flag_word[29] && !flag_word[31] && !flag_word[28]))
        else $error("equal compare with inconsistent flags");

    assert_illegal_cause_R9: assert property (@(posedge clk) disable iff (rst)
        illegal_op |-> $past(op_valid))
        else $error("illegal strobe without an issued operation");

endmodule

// File: tb/tb_dwcp_alu.sv
module tb_dwcp_alu;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [1:0]  op_group = '0;
    logic [2:0]  op_code = '0;
    logic [3:0]  rd_idx = '0, rs1_idx = '0, rs2_idx = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata, flag_word;
    logic        illegal_op;

    always #10 clk = ~clk;

    dwcp_alu dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_group(op_group),
        .op_code(op_code), .rd_idx(rd_idx), .rs1_idx(rs1_idx), .rs2_idx(rs2_idx),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .flag_word(flag_word),
        .illegal_op(illegal_op)
    );

    typedef struct {
        logic [31:0] rd;
        logic [31:0] fl;
        logic        ill;
        string       tag;
    } item_t;

    item_t       q[$];
    int          checks = 0, fails = 0;
    bit          done = 0;
    logic [63:0] m[16];
    logic [31:0] e_rd = '0, e_fl = '0;

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] bfl32(input logic [31:0] x, input logic [31:0] y);
        logic signed [32:0] e;
        logic [31:0] r;
        e = $signed({x[31], x}) - $signed({y[31], y});
        r = x - y;
        return {r[31], x == y, x >= y, e[32] != e[31], 28'h0};
    endfunction

    function automatic logic [31:0] bfl64(input logic [63:0] x, input logic [63:0] y);
        logic signed [64:0] e;
        logic [63:0] r;
        e = $signed({x[63], x}) - $signed({y[63], y});
        r = x - y;
        return {r[63], x == y, x >= y, e[64] != e[63], 28'h0};
    endfunction

    function automatic logic [63:0] bsh(input logic [63:0] x, input int w, input logic [31:0] amt);
        logic [63:0] mask;
        logic        s;
        longint      cnt;
        mask = (w == 64) ? '1 : 64'hFFFF_FFFF;
        x = x & mask;
        s = x[w-1];
        cnt = amt[31] ? -longint'($signed(amt)) : longint'(amt);
        if (cnt > 70) cnt = 70;
        for (longint i = 0; i < cnt; i++) begin
            if (amt[31]) x = (x >> 1) | (64'(s) << (w - 1));
            else         x = (x << 1) & mask;
        end
        return x;
    endfunction

    task automatic op(input logic [1:0] g, input logic [2:0] c, input int rd, input int s1,
                      input int s2, input logic [31:0] w, input string tag);
        logic [63:0] a, b, d, n;
        logic        ill;
        item_t       it;
        a = m[s1]; b = m[s2]; d = m[rd]; n = d; ill = 1'b0;
        case (g)
            2'd0: case (c)
                3'd0: n[31:0]  = w;
                3'd1: n[63:32] = w;
                3'd2: e_rd = a[31:0];
                3'd3: e_rd = a[63:32];
                3'd4: e_fl = bfl32(a[31:0], b[31:0]);
                3'd5: e_fl = bfl64(a, b);
                default: ill = 1'b1;
            endcase
            2'd1: case (c)
                3'd0: n[31:0] = a[31] ? 32'(0 - a[31:0]) : a[31:0];
                3'd1: n = a[63] ? (64'd0 - a) : a;
                3'd2: n[31:0] = 32'(0 - a[31:0]);
                3'd3: n = 64'd0 - a;
                3'd4: n[31:0] = a[31:0] + b[31:0];
                3'd5: n = a + b;
                3'd6: n[31:0] = a[31:0] - b[31:0];
                default: n = a - b;
            endcase
            2'd2: case (c)
                3'd0: n[31:0] = 32'(a[31:0] * b[31:0]);
                3'd1: n = a * b;
                3'd2: n[31:0] = d[31:0] + 32'(a[31:0] * b[31:0]);
                3'd3: n[31:0] = d[31:0] - 32'(a[31:0] * b[31:0]);
                default: ill = 1'b1;
            endcase
            default: case (c)
                3'd0: n[31:0] = bsh(a, 32, w)[31:0];
                3'd1: n = bsh(a, 64, w);
                default: ill = 1'b1;
            endcase
        endcase
        if (!ill) m[rd] = n;
        it.rd = e_rd; it.fl = e_fl; it.ill = ill; it.tag = tag;
        q.push_back(it);
        op_valid = 1'b1; op_group = g; op_code = c;
        rd_idx = 4'(rd); rs1_idx = 4'(s1); rs2_idx = 4'(s2); host_wdata = w;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic put(input int r, input logic [63:0] v, input string tag);
        op(2'd0, 3'd0, r, 0, 0, v[31:0], tag);
        op(2'd0, 3'd1, r, 0, 0, v[63:32], tag);
    endtask

    task automatic get(input int r, input string tag);
        op(2'd0, 3'd2, 0, r, 0, 32'h0, tag);
        op(2'd0, 3'd3, 0, r, 0, 32'h0, tag);
    endtask

    // monitor: compares each issued operation one edge after issue
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                chk(it.tag, "host_rdata", 64'(host_rdata), 64'(it.rd));
                chk(it.tag, "flag_word",  64'(flag_word),  64'(it.fl));
                chk(it.tag, "illegal_op", 64'(illegal_op), 64'(it.ill));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) m[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state at the ports and in every register
        chk("R1", "host_rdata", 64'(host_rdata), 64'h0);
        chk("R1", "flag_word",  64'(flag_word),  64'h0);
        chk("R1", "illegal_op", 64'(illegal_op), 64'h0);
        for (int r = 0; r < 16; r++) get(r, "R1");

        // R2: independent half moves and read-back
        op(2'd0, 3'd0, 1, 0, 0, 32'hFFFF_FFFF, "R2");
        get(1, "R2");
        op(2'd0, 3'd1, 1, 0, 0, 32'h0000_0001, "R2");
        get(1, "R2");
        put(2, 64'h0000_0000_0000_0001, "R2");
        get(2, "R2");

        // R3: 64-bit add and subtract across the halves
        op(2'd1, 3'd5, 3, 1, 2, 0, "R3");
        get(3, "R3");
        op(2'd1, 3'd7, 6, 2, 1, 0, "R3");
        get(6, "R3");

        // R4: 32-bit add/sub leave the destination upper half alone
        op(2'd0, 3'd1, 4, 0, 0, 32'hAAAA_5555, "R4");
        op(2'd1, 3'd4, 4, 1, 2, 0, "R4");
        get(4, "R4");
        op(2'd1, 3'd6, 4, 2, 1, 0, "R4");
        get(4, "R4");

        // R5: abs / negate, including the most negative values
        put(7, 64'h1234_5678_8000_0000, "R5");
        op(2'd1, 3'd0, 8, 7, 0, 0, "R5"); get(8, "R5");
        op(2'd1, 3'd2, 8, 1, 0, 0, "R5"); get(8, "R5");
        put(9, 64'hFFFF_FFFF_FFFF_FFF6, "R5");
        op(2'd1, 3'd1, 10, 9, 0, 0, "R5"); get(10, "R5");
        op(2'd1, 3'd3, 10, 9, 0, 0, "R5"); get(10, "R5");
        put(11, 64'h8000_0000_0000_0000, "R5");
        op(2'd1, 3'd1, 12, 11, 0, 0, "R5"); get(12, "R5");

        // R6: multiplies and accumulates
        put(13, 64'h0000_0003_FFFF_FFFD, "R6");
        put(14, 64'h0000_0002_0001_0007, "R6");
        op(2'd2, 3'd0, 15, 13, 14, 0, "R6"); get(15, "R6");
        op(2'd2, 3'd1, 15, 13, 14, 0, "R6"); get(15, "R6");
        op(2'd2, 3'd2, 15, 13, 14, 0, "R6"); get(15, "R6");
        op(2'd2, 3'd3, 15, 14, 14, 0, "R6"); get(15, "R6");

        // R7: signed shift amounts and saturation of the magnitude
        put(5, 64'h8765_4321_F000_00F1, "R7");
        op(2'd3, 3'd0, 8, 5, 0, 32'd4, "R7");          get(8, "R7");
        op(2'd3, 3'd0, 8, 5, 0, -32'sd4, "R7");        get(8, "R7");
        op(2'd3, 3'd0, 8, 5, 0, 32'd0, "R7");          get(8, "R7");
        op(2'd3, 3'd0, 8, 5, 0, 32'd32, "R7");         get(8, "R7");
        op(2'd3, 3'd0, 8, 5, 0, -32'sd40, "R7");       get(8, "R7");
        op(2'd3, 3'd0, 8, 5, 0, 32'h8000_0000, "R7");  get(8, "R7");
        op(2'd3, 3'd1, 8, 5, 0, 32'd36, "R7");         get(8, "R7");
        op(2'd3, 3'd1, 8, 5, 0, -32'sd36, "R7");       get(8, "R7");
        op(2'd3, 3'd1, 8, 5, 0, 32'd64, "R7");         get(8, "R7");
        op(2'd3, 3'd1, 8, 5, 0, -32'sd70, "R7");       get(8, "R7");

        // R8: compares
        op(2'd0, 3'd4, 0, 1, 1, 0, "R8");
        op(2'd0, 3'd4, 0, 2, 1, 0, "R8");
        op(2'd0, 3'd4, 0, 1, 2, 0, "R8");
        put(9, 64'h7FFF_FFFF_7FFF_FFFF, "R8");
        op(2'd0, 3'd4, 0, 9, 1, 0, "R8");
        op(2'd0, 3'd5, 0, 9, 11, 0, "R8");
        op(2'd0, 3'd5, 0, 3, 3, 0, "R8");
        op(2'd0, 3'd5, 0, 2, 3, 0, "R8");
        get(2, "R8");

        // R9: unassigned codes change nothing
        op(2'd0, 3'd7, 3, 1, 2, 32'h1111_1111, "R9");
        op(2'd2, 3'd5, 3, 1, 2, 0, "R9");
        op(2'd3, 3'd3, 3, 1, 2, 32'd1, "R9");
        op(2'd0, 3'd6, 3, 1, 2, 32'h2222_2222, "R9");
        get(3, "R9");

        // R10: idle cycles with busy inputs
        op_group = 2'd1; op_code = 3'd5; rd_idx = 4'd3; rs1_idx = 4'd1; rs2_idx = 4'd1;
        repeat (3) @(negedge clk);
        chk("R10", "illegal_op", 64'(illegal_op), 64'h0);
        get(3, "R10");

        repeat (3) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule